// File: doc/BRIEF.md
# Slot-Timed Serial Word Receiver

This block is the receiving end of one node on a shared single-wire data line. Every node runs from the same system clock, so no bit clock travels with the data. A frame strobe marks the start of each time slice. The slice is divided into fixed-length slots. The node owns exactly one slot, chosen by a static slot-index input, so no address field is needed.

After a strobe, the receiver counts clocks until its own slot opens. It then listens for a falling edge on the line, which is the start bit, for a bounded number of clocks. Once the start bit is found, it shifts in a fixed-length word. Each data bit is sampled at a programmable position inside the bit, so the best centre point can be found by sweeping that position.

A completed word is presented with a one-cycle valid pulse. If no start bit arrives in the listening window, the receiver raises a one-cycle error pulse and ignores the line until the next strobe.

Top module: `srx_slot_rx`

## Requirements
- R1: While reset is held low at a clock edge, `valid_o`, `err_o` and `word_o` are all zero after that edge.
- R2: A word is a start bit (line low) followed by 32 data bits, each lasting 8 clocks, sent most significant bit first. Outside the clock where `valid_o` is high, `word_o` holds its previous value. `valid_o` is a single-cycle pulse.
- R3: Let the start edge be the clock edge at which the line is first seen low after being high. Data bit i (i = 0 for the first bit) is sampled at start edge + 8 + ofs + 8·i, where ofs is `samp_ofs_i` captured at the start edge. `valid_o` is high directly after the edge at start edge + 256 + ofs.
- R4: In each frame only the word sent in slot `slot_idx_i` is captured. Words in any other slot never reach `word_o`.
- R5: Let t0 be the edge at which `sof_i` is high, S = 320 clocks per slot, and T = `tmo_i`. The start edge of slot k is accepted when it falls on an edge from t0 + k·S + 3 through t0 + k·S + T + 3, inclusive.
- R6: If no start edge is accepted in that window, `err_o` pulses for one cycle directly after edge t0 + k·S + T + 3. The line is then ignored until the next strobe, so a later word in the same frame is not captured.
- R7: A strobe abandons any listening or reception in progress. The abandoned word yields neither a valid pulse nor an error pulse, and slot counting restarts from the new strobe.
- R8: At most one valid pulse or one error pulse is produced per frame, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_i | input | 1 | Frame strobe, high for one cycle at the start of a time slice |
| line_i | input | 1 | Shared serial data line, idles high |
| slot_idx_i | input | SLOT_W (3) | Index of the slot this node owns |
| samp_ofs_i | input | log2(BIT_CLKS) (3) | Sampling position inside each bit, in clocks |
| tmo_i | input | TMO_W (12) | Listening window length after the slot opens, in clocks |
| word_o | output | DATA_BITS (32) | Last received word |
| valid_o | output | 1 | One-cycle pulse when `word_o` is updated |
| err_o | output | 1 | One-cycle pulse when the slot window closes with no start bit |

## Verification
The bench drives every bit with the inverse value everywhere except at one chosen position. A sampler that is off by one clock, or that ignores `samp_ofs_i`, therefore returns the complemented word. It puts the start bit exactly on the last accepted edge of the window and again one edge later. A window counter that is one cycle short or long either flags a false error or captures a word it should have dropped. It also fills the neighbouring slots with different words, so that a slot count off by one captures the wrong slot's data. Finally it fires a strobe in the middle of a word and in the middle of a window, which exposes a design that leaks a stale valid or error pulse, or that keeps counting from the old frame.

// File: rtl/srx_pkg.sv
// Shared types for the slot-timed serial receiver.
// Assumes: all users compile this package first.
package srx_pkg;

    // Listening state of the start-edge hunter.
    typedef enum logic {
        HUNT_IDLE  = 1'b0,
        HUNT_ARMED = 1'b1
    } hunt_state_e;

    // Activity of the bit sampler.
    typedef enum logic {
        SMP_IDLE  = 1'b0,
        SMP_SHIFT = 1'b1
    } smp_state_e;

endpackage

// File: rtl/srx_slot_count.sv
// Counts fixed-length slots from the frame strobe and pulses slot_open_o
// one cycle when the slot named by slot_idx_i begins.
// Assumes: sof_i is synchronous to clk; slot_idx_i is static within a frame.
module srx_slot_count #(
    parameter int SLOT_CLKS = 320,
    parameter int SLOT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic [SLOT_W-1:0] slot_idx_i,
    output logic              slot_open_o
);
    localparam int CW = $clog2(SLOT_CLKS);

    logic              counting;
    logic [CW-1:0]     clk_cnt;
    logic [SLOT_W-1:0] slot_cnt;

    // Advance the clock and slot counters; fire once on reaching our slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            counting    <= 1'b0;
            clk_cnt     <= '0;
            slot_cnt    <= '0;
            slot_open_o <= 1'b0;
        end else begin
            slot_open_o <= 1'b0;
            if (sof_i) begin
                counting <= 1'b1;
                clk_cnt  <= '0;
                slot_cnt <= '0;
            end else if (counting) begin
                if (slot_cnt == slot_idx_i) begin
                    slot_open_o <= 1'b1;
                    counting    <= 1'b0;
                end else if (clk_cnt == CW'(SLOT_CLKS - 1)) begin
                    clk_cnt  <= '0;
                    slot_cnt <= slot_cnt + 1'b1;
                end else begin
                    clk_cnt <= clk_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/srx_edge_hunt.sv
// Listens for the start-bit falling edge during a bounded window after the
// slot opens. Emits start_o combinationally on the detecting edge, or a
// registered err_o pulse when the window closes empty.
// Assumes: line_i is already synchronous to clk (common clock domain).
module srx_edge_hunt #(
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             slot_open_i,
    input  logic             line_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             start_o,
    output logic             armed_o,
    output logic             err_o
);
    import srx_pkg::*;

    hunt_state_e      state;
    logic             line_d;
    logic [TMO_W-1:0] wait_cnt;

    assign armed_o = (state == HUNT_ARMED);
    // High-to-low transition seen while armed and no strobe this cycle.
    assign start_o = armed_o && line_d && !line_i && !sof_i;

    // Track the line, the window counter and the listening state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= HUNT_IDLE;
            line_d   <= 1'b1;
            wait_cnt <= '0;
            err_o    <= 1'b0;
        end else begin
            line_d <= line_i;
            err_o  <= 1'b0;
            if (sof_i) begin
                state <= HUNT_IDLE;
            end else if (slot_open_i) begin
                state    <= HUNT_ARMED;
                wait_cnt <= '0;
            end else if (state == HUNT_ARMED) begin
                if (start_o) begin
                    state <= HUNT_IDLE;
                end else if (wait_cnt == tmo_i) begin
                    err_o <= 1'b1;
                    state <= HUNT_IDLE;
                end else begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/srx_bit_sampler.sv
// Times each bit from the start edge and shifts the line in, MSB first,
// at a fixed offset inside every bit. Presents the word with a valid pulse.
// Assumes: BIT_CLKS is a power of two; abort_i outranks start_i.
module srx_bit_sampler #(
    parameter int DATA_BITS = 32,
    parameter int BIT_CLKS  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        abort_i,
    input  logic                        start_i,
    input  logic                        line_i,
    input  logic [$clog2(BIT_CLKS)-1:0] ofs_i,
    output logic                        busy_o,
    output logic [DATA_BITS-1:0]        word_o,
    output logic                        valid_o
);
    import srx_pkg::*;

    localparam int PH_W  = $clog2(BIT_CLKS);
    localparam int CNT_W = $clog2(BIT_CLKS * (DATA_BITS + 1));
    localparam int HI_W  = CNT_W - PH_W;
    localparam logic [HI_W-1:0] LAST_BIT = HI_W'(DATA_BITS);

    smp_state_e           state;
    logic [CNT_W-1:0]     cnt;
    logic [PH_W-1:0]      ofs_q;
    logic [DATA_BITS-1:0] shreg;
    logic                 sample;
    logic                 last;

    assign busy_o = (state == SMP_SHIFT);
    // Sample point: chosen phase of any bit period after the start bit.
    assign sample = busy_o && (cnt[PH_W-1:0] == ofs_q) && (cnt[CNT_W-1:PH_W] != '0);
    assign last   = sample && (cnt[CNT_W-1:PH_W] == LAST_BIT);

    // Run the bit timer, collect samples and publish the finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SMP_IDLE;
            cnt     <= '0;
            ofs_q   <= '0;
            shreg   <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (abort_i) begin
                state <= SMP_IDLE;
            end else if (start_i) begin
                state <= SMP_SHIFT;
                cnt   <= CNT_W'(1);
                ofs_q <= ofs_i;
            end else if (busy_o) begin
                cnt <= cnt + 1'b1;
                if (sample) begin
                    shreg <= {shreg[DATA_BITS-2:0], line_i};
                end
                if (last) begin
                    state   <= SMP_IDLE;
                    valid_o <= 1'b1;
                    word_o  <= {shreg[DATA_BITS-2:0], line_i};
                end
            end
        end
    end

endmodule

// File: rtl/srx_slot_rx.sv
// Top of the slot-timed serial receiver: slot counter, start-edge hunter
// and bit sampler in a chain, all restarted by the frame strobe.
// Assumes: every node shares clk; inputs are synchronous to it.
module srx_slot_rx #(
    parameter int DATA_BITS = 32,
    parameter int BIT_CLKS  = 8,
    parameter int SLOT_CLKS = 320,
    parameter int SLOT_W    = 3,
    parameter int TMO_W     = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sof_i,
    input  logic                        line_i,
    input  logic [SLOT_W-1:0]           slot_idx_i,
    input  logic [$clog2(BIT_CLKS)-1:0] samp_ofs_i,
    input  logic [TMO_W-1:0]            tmo_i,
    output logic [DATA_BITS-1:0]        word_o,
    output logic                        valid_o,
    output logic                        err_o
);
    logic slot_open;
    logic start_seen;
    logic hunt_armed;
    logic rx_busy;

    srx_slot_count #(
        .SLOT_CLKS (SLOT_CLKS),
        .SLOT_W    (SLOT_W)
    ) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof_i),
        .slot_idx_i  (slot_idx_i),
        .slot_open_o (slot_open)
    );

    srx_edge_hunt #(
        .TMO_W (TMO_W)
    ) u_hunt (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof_i),
        .slot_open_i (slot_open),
        .line_i      (line_i),
        .tmo_i       (tmo_i),
        .start_o     (start_seen),
        .armed_o     (hunt_armed),
        .err_o       (err_o)
    );

    srx_bit_sampler #(
        .DATA_BITS (DATA_BITS),
        .BIT_CLKS  (BIT_CLKS)
    ) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort_i (sof_i),
        .start_i (start_seen),
        .line_i  (line_i),
        .ofs_i   (samp_ofs_i),
        .busy_o  (rx_busy),
        .word_o  (word_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/srx_slot_rx_chk.sv
// Protocol checks on the receiver outputs and on the hand-off between
// hunter and sampler. Attached to every srx_slot_rx by the bind below.
module srx_slot_rx_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sof_i,
    input logic [W-1:0] word_o,
    input logic         valid_o,
    input logic         err_o,
    input logic         hunt_armed,
    input logic         rx_busy
);
    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o != $past(word_o)) |-> valid_o);

    // R6
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R7
    sof_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (!valid_o && !err_o));

    // R8
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));

    // R8
    hunt_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hunt_armed, rx_busy}));

endmodule

bind srx_slot_rx srx_slot_rx_chk #(.W(DATA_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof_i      (sof_i),
    .word_o     (word_o),
    .valid_o    (valid_o),
    .err_o      (err_o),
    .hunt_armed (hunt_armed),
    .rx_busy    (rx_busy)
);

// File: tb/srx_slot_rx_tb.sv
module srx_slot_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_BITS  = 32;
    localparam int BIT_CLKS   = 8;
    localparam int SLOT_CLKS  = 320;
    localparam int SLOT_W     = 3;
    localparam int TMO_W      = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sof_i = 1'b0;
    logic                 line_i = 1'b1;
    logic [SLOT_W-1:0]    slot_idx_i = '0;
    logic [2:0]           samp_ofs_i = 3'd4;
    logic [TMO_W-1:0]     tmo_i = 12'd100;
    logic [DATA_BITS-1:0] word_o;
    logic                 valid_o;
    logic                 err_o;

    srx_slot_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .line_i     (line_i),
        .slot_idx_i (slot_idx_i),
        .samp_ofs_i (samp_ofs_i),
        .tmo_i      (tmo_i),
        .word_o     (word_o),
        .valid_o    (valid_o),
        .err_o      (err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edge number: value after a posedge names that edge.
    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    int n_checks = 0;
    int n_fails  = 0;

    // Output monitor, sampled away from the active edge.
    int          n_valid = 0;
    int          n_err = 0;
    int          last_vcyc = 0;
    int          last_ecyc = 0;
    logic [31:0] last_word = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                n_valid   = n_valid + 1;
                last_word = word_o;
                last_vcyc = cyc;
            end
            if (err_o) begin
                n_err     = n_err + 1;
                last_ecyc = cyc;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Frame description used by the driver and the expectation model.
    logic [31:0] f_word [8];
    int          f_lead [8];
    bit          f_on   [8];
    int          f_es   [8];
    bit          f_glitch;
    int          f_pos;
    int          f_t0;

    task automatic clear_cfg();
        for (int i = 0; i < 8; i++) begin
            f_on[i]   = 1'b0;
            f_lead[i] = 5;
            f_word[i] = $urandom;
            f_es[i]   = 0;
        end
        f_glitch = 1'b0;
        f_pos    = 0;
    endtask

    // Called at a negedge; returns at the negedge just before edge target.
    task automatic wait_edge(input int target);
        while (cyc + 1 < target) @(negedge clk);
    endtask

    task automatic pulse_sof();
        sof_i = 1'b1;
        f_t0  = cyc + 1;
        @(negedge clk);
        sof_i = 1'b0;
    endtask

    // Start bit then nbits data bits MSB first; in glitch mode only phase
    // f_pos of each bit carries the true value.
    task automatic drive_word(input logic [31:0] w, input int nbits);
        line_i = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            for (int q = 0; q < BIT_CLKS; q++) begin
                line_i = (f_glitch && q != f_pos) ? ~w[31-i] : w[31-i];
                @(negedge clk);
            end
        end
        line_i = 1'b1;
    endtask

    task automatic send_frame(input int nslots);
        pulse_sof();
        for (int s = 0; s < nslots; s++) begin
            if (f_on[s]) begin
                wait_edge(f_t0 + s*SLOT_CLKS + f_lead[s]);
                f_es[s] = cyc + 1;
                drive_word(f_word[s], DATA_BITS);
            end
        end
        wait_edge(f_t0 + nslots*SLOT_CLKS + 20);
    endtask

    // Expected outcome from the requirements, compared with the monitor.
    task automatic check_frame(input string req, input int v0, input int e0);
        int k; int ofs; int tt; bit acc; logic [31:0] ew;
        k   = int'(slot_idx_i);
        ofs = int'(samp_ofs_i);
        tt  = int'(tmo_i);
        acc = f_on[k] && f_lead[k] >= 3 && f_lead[k] <= tt + 3;
        ew  = (f_glitch && f_pos != ofs) ? ~f_word[k] : f_word[k];
        if (acc) begin
            check(n_valid - v0 == 1, "R8", "valid pulses", n_valid - v0, 1);
            check(last_word == ew, req, "word", last_word, ew);
            check(last_vcyc == f_es[k] + BIT_CLKS*DATA_BITS + ofs, "R3",
                  "valid edge", last_vcyc, f_es[k] + BIT_CLKS*DATA_BITS + ofs);
            check(n_err == e0, "R5", "error pulses", n_err - e0, 0);
        end else begin
            check(n_valid == v0, "R6", "valid pulses", n_valid - v0, 0);
            check(n_err - e0 == 1, "R6", "error pulses", n_err - e0, 1);
            check(last_ecyc == f_t0 + k*SLOT_CLKS + tt + 3, "R5", "error edge",
                  last_ecyc, f_t0 + k*SLOT_CLKS + tt + 3);
        end
    endtask

    task automatic run_frame(input string req, input int nslots);
        int v0; int e0;
        v0 = n_valid;
        e0 = n_err;
        send_frame(nslots);
        check_frame(req, v0, e0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL R2 watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int v0; int e0;
        void'($urandom(32'h5EED_0A17));
        clear_cfg();

        // R1: reset state
        repeat (4) @(negedge clk);
        check(valid_o == 1'b0, "R1", "valid in reset", valid_o, 0);
        check(err_o == 1'b0, "R1", "err in reset", err_o, 0);
        check(word_o == '0, "R1", "word in reset", word_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: basic word in slot 0, neighbour occupied
        clear_cfg();
        slot_idx_i = 3'd0; samp_ofs_i = 3'd4; tmo_i = 12'd100;
        f_on[0] = 1; f_word[0] = 32'hA5A5_0F0F; f_lead[0] = 5;
        f_on[1] = 1; f_word[1] = 32'h1234_5678; f_lead[1] = 7;
        run_frame("R2", 2);

        // R2/R4: all-zero and all-one words in later slots
        clear_cfg();
        slot_idx_i = 3'd3;
        for (int s = 0; s < 5; s++) begin f_on[s] = 1; f_lead[s] = 4 + s; end
        f_word[3] = 32'h0000_0000;
        run_frame("R4", 5);
        clear_cfg();
        slot_idx_i = 3'd2;
        for (int s = 0; s < 4; s++) begin f_on[s] = 1; f_lead[s] = 10; end
        f_word[2] = 32'hFFFF_FFFF;
        f_word[1] = 32'h0000_0000;
        f_word[3] = 32'h0000_0000;
        run_frame("R4", 4);

        // R3: offset sweep, only the chosen phase carries true data
        for (int o = 0; o < 8; o++) begin
            clear_cfg();
            slot_idx_i = 3'd1; samp_ofs_i = 3'(o);
            f_glitch = 1; f_pos = o;
            f_on[1] = 1; f_lead[1] = 6;
            run_frame("R3", 2);
        end
        // R3: sampling at the wrong phase must return the complement
        clear_cfg();
        slot_idx_i = 3'd0; samp_ofs_i = 3'd5;
        f_glitch = 1; f_pos = 2;
        f_on[0] = 1; f_word[0] = 32'hC3C3_9696; f_lead[0] = 8;
        run_frame("R3", 1);

        // R5: last accepted edge of the window, and the minimum window
        clear_cfg();
        slot_idx_i = 3'd1; samp_ofs_i = 3'd4; tmo_i = 12'd20;
        f_on[1] = 1; f_lead[1] = 23;
        run_frame("R5", 2);
        clear_cfg();
        tmo_i = 12'd0; slot_idx_i = 3'd0;
        f_on[0] = 1; f_lead[0] = 3;
        run_frame("R5", 1);

        // R6: start one edge late, later slot word must be ignored
        clear_cfg();
        slot_idx_i = 3'd1; tmo_i = 12'd20;
        f_on[1] = 1; f_lead[1] = 24;
        f_on[2] = 1; f_lead[2] = 5;
        run_frame("R6", 3);
        // R6: slot left empty
        clear_cfg();
        slot_idx_i = 3'd2; tmo_i = 12'd60;
        f_on[0] = 1; f_on[1] = 1; f_on[3] = 1;
        run_frame("R6", 4);

        // R7: strobe in the middle of a word restarts counting
        clear_cfg();
        slot_idx_i = 3'd1; tmo_i = 12'd100; samp_ofs_i = 3'd4;
        v0 = n_valid; e0 = n_err;
        pulse_sof();
        wait_edge(f_t0 + SLOT_CLKS + 6);
        drive_word(32'hDEAD_BEEF, 12);
        pulse_sof();
        wait_edge(f_t0 + SLOT_CLKS + 140);
        check(n_valid == v0, "R7", "valid after mid-word strobe", n_valid - v0, 0);
        check(n_err - e0 == 1, "R7", "errors after restart", n_err - e0, 1);
        check(last_ecyc == f_t0 + SLOT_CLKS + 103, "R7", "error edge after restart",
              last_ecyc, f_t0 + SLOT_CLKS + 103);

        // R7: strobe during listening, new frame's word accepted, old error dropped
        clear_cfg();
        slot_idx_i = 3'd0; tmo_i = 12'd200;
        v0 = n_valid; e0 = n_err;
        pulse_sof();
        wait_edge(f_t0 + 50);
        pulse_sof();
        wait_edge(f_t0 + 10);
        f_es[0] = cyc + 1;
        drive_word(32'h0BAD_F00D, DATA_BITS);
        wait_edge(f_t0 + 2*SLOT_CLKS);
        check(n_valid - v0 == 1, "R7", "valid after listen restart", n_valid - v0, 1);
        check(last_word == 32'h0BAD_F00D, "R7", "word after listen restart",
              last_word, 32'h0BAD_F00D);
        check(n_err == e0, "R7", "stale error", n_err - e0, 0);

        // Random frames
        for (int n = 0; n < 24; n++) begin
            int ns;
            clear_cfg();
            slot_idx_i = 3'($urandom_range(0, 3));
            tmo_i      = 12'($urandom_range(30, 200));
            samp_ofs_i = 3'($urandom_range(0, 7));
            f_glitch   = $urandom_range(0, 1) == 1;
            f_pos      = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : int'(samp_ofs_i);
            ns = int'(slot_idx_i) + 2;
            for (int s = 0; s < ns; s++) begin
                f_on[s]   = 1;
                f_lead[s] = $urandom_range(3, 30);
            end
            run_frame("R4", ns);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule